// File: doc/BRIEF.md
# Load/Store Port Request Master

This block sits on the requesting side of a load/store port that allows one transaction at a time. A client hands it a command through a valid/ready handshake. The command holds the direction (load or store), the address, a 4-bit byte length and, for a store, 64 bits of data. The block then drives the port's request lines and holds the address steady for the whole transaction. It waits for the port to accept the address or to report an exception. For a store it supplies the data only after the address is accepted. For a load it captures the read data.

Every transaction that completes produces a single-cycle response. The response carries the load data, an exception flag or a timeout flag. A programmable timeout limits how long any wait may last. An abort input drops the request at once: it pulses the port's abort line for one cycle and returns the block to idle without producing a response.

Top module: `ldst_req_master`

## Requirements
- R1: A load request drives `pt_ld_o`, a store request drives `pt_st_o`, and the two are never high together. Both are low while no transaction is in progress.
- R2: `pt_addr_o`, `pt_len_o` and `pt_addr_vld_o` are driven from the cycle after the command is accepted. They stay unchanged until the cycle in which the transaction ends.
- R3: While the address is outstanding, `pt_addr_ack_i` moves a load into its data-wait phase and moves a store into its data-pulse phase on the next cycle.
- R4: `pt_exc_i` ends the transaction in any active state, and it wins over an acknowledge or load data seen in the same cycle. On the next cycle the response shows `rsp_exc_o`=1, `rsp_tmo_o`=0 and `rsp_rdata_o`=0.
- R5: In the data-wait phase, a cycle with `pt_ld_vld_i` high captures `pt_ld_data_i` and ends the load. The next cycle returns that value on `rsp_rdata_o` with both flags at 0. `pt_ld_vld_i` is ignored while the address is still outstanding.
- R6: `pt_st_vld_o` is high for exactly one cycle per store: the cycle after the address acknowledge. In that cycle `pt_st_data_o` carries the command's store data. At all other times `pt_st_vld_o` is low.
- R7: After the store pulse, the store completes on the first cycle in which `pt_busy_i` is low. The response follows on the next cycle with `rsp_rdata_o`=0 and both flags at 0.
- R8: With `tmo_limit_i`=N and N nonzero, a wait phase (address, load data or store drain) that lasts N cycles with no event ends the transaction. The response has `rsp_tmo_o`=1 and `rsp_rdata_o`=0. With N=0 there is no timeout.
- R9: `abort_i` during an active transaction returns the block to idle on the next cycle. In that cycle `pt_abort_o` is high for one cycle, the request lines are low and no response is produced. `abort_i` while idle has no effect.
- R10: `cmd_ready_o` is high only when the block is idle and `pt_busy_i` is low. A command offered at any other time is not taken.
- R11: `rsp_valid_o` is high for exactly one cycle per completed transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command can be taken |
| cmd_is_st_i | input | 1 | 1 = store, 0 = load |
| cmd_addr_i | input | ADDR_W | Command address |
| cmd_len_i | input | LEN_W | Byte length |
| cmd_wdata_i | input | DATA_W | Store data |
| abort_i | input | 1 | Abort the current transaction |
| tmo_limit_i | input | TMO_W | Wait limit in cycles, 0 disables |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_rdata_o | output | DATA_W | Load data, zero otherwise |
| rsp_exc_o | output | 1 | Ended by exception |
| rsp_tmo_o | output | 1 | Ended by timeout |
| pt_ld_o | output | 1 | Port load request |
| pt_st_o | output | 1 | Port store request |
| pt_addr_o | output | ADDR_W | Port address |
| pt_addr_vld_o | output | 1 | Port address valid |
| pt_len_o | output | LEN_W | Port byte length |
| pt_abort_o | output | 1 | Port abort pulse |
| pt_busy_i | input | 1 | Port busy |
| pt_addr_ack_i | input | 1 | Address accepted pulse |
| pt_exc_i | input | 1 | Exception pulse |
| pt_ld_vld_i | input | 1 | Load data valid pulse |
| pt_ld_data_i | input | DATA_W | Load data |
| pt_st_vld_o | output | 1 | Store data valid pulse |
| pt_st_data_o | output | DATA_W | Store data |

## Verification
The bench builds the block with its default widths: a 48-bit address, 64-bit data, a 4-bit length and a 16-bit timeout counter. At run time it sets the timeout limit to 6 cycles. That limit is longer than any acknowledge, load-data or drain delay in the stimulus table, so correct transactions never time out. It is also short enough that an address phase with no answer, or a load that never returns data, reaches timeout within a few cycles; the bench checks the exact cycle of that timeout. A separate test sets the limit to 0 and holds a load for twenty cycles, which shows that a zero limit disables the timeout.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,  // no transaction
    ST_ADDR,  // address outstanding
    ST_LDAT,  // load: waiting for data
    ST_SPUL,  // store: data pulse
    ST_SDRN   // store: waiting for busy to fall
  } ldst_st_e;

  typedef enum logic [1:0] {
    END_OK,
    END_EXC,
    END_TMO
  } ldst_end_e;
endpackage

// File: rtl/ldst_tmo.sv
module ldst_tmo #(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expire_o
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + TMO_W'(1);
  end

  assign expire_o = run_i && (limit_i != '0) && (cnt_q == limit_i - TMO_W'(1));
endmodule

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      fire_i,
  input  logic      is_st_i,
  input  logic      abort_i,
  input  logic      busy_i,
  input  logic      ack_i,
  input  logic      exc_i,
  input  logic      ld_vld_i,
  input  logic      expire_i,
  output ldst_st_e  state_o,
  output logic      clr_o,
  output logic      done_o,
  output ldst_end_e kind_o,
  output logic      ld_cap_o,
  output logic      abort_o
);
  ldst_st_e st_q, st_d;
  logic     abort_q;

  always_comb begin
    st_d     = st_q;
    done_o   = 1'b0;
    kind_o   = END_OK;
    ld_cap_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (fire_i) st_d = ST_ADDR;
      ST_ADDR: begin
        if (exc_i) begin
          done_o = 1'b1; kind_o = END_EXC; st_d = ST_IDLE;
        end else if (ack_i) begin
          st_d = is_st_i ? ST_SPUL : ST_LDAT;
        end else if (expire_i) begin
          done_o = 1'b1; kind_o = END_TMO; st_d = ST_IDLE;
        end
      end
      ST_LDAT: begin
        if (exc_i) begin
          done_o = 1'b1; kind_o = END_EXC; st_d = ST_IDLE;
        end else if (ld_vld_i) begin
          done_o = 1'b1; ld_cap_o = 1'b1; st_d = ST_IDLE;
        end else if (expire_i) begin
          done_o = 1'b1; kind_o = END_TMO; st_d = ST_IDLE;
        end
      end
      ST_SPUL: begin
        if (exc_i) begin
          done_o = 1'b1; kind_o = END_EXC; st_d = ST_IDLE;
        end else begin
          st_d = ST_SDRN;
        end
      end
      ST_SDRN: begin
        if (exc_i) begin
          done_o = 1'b1; kind_o = END_EXC; st_d = ST_IDLE;
        end else if (!busy_i) begin
          done_o = 1'b1; st_d = ST_IDLE;
        end else if (expire_i) begin
          done_o = 1'b1; kind_o = END_TMO; st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    // abort overrides every completion
    if (abort_i && st_q != ST_IDLE) begin
      st_d     = ST_IDLE;
      done_o   = 1'b0;
      ld_cap_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      abort_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      abort_q <= abort_i && (st_q != ST_IDLE);
    end
  end

  assign state_o = st_q;
  assign clr_o   = (st_d != st_q);
  assign abort_o = abort_q;
endmodule

// File: rtl/ldst_dpath.sv
module ldst_dpath
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 64,
  parameter int LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              is_st_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              done_i,
  input  ldst_end_e         kind_i,
  input  logic              ld_cap_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output logic              is_st_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_exc_o,
  output logic              rsp_tmo_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      is_st_o <= 1'b0;
      addr_o  <= '0;
      len_o   <= '0;
      wdata_o <= '0;
    end else if (fire_i) begin
      is_st_o <= is_st_i;
      addr_o  <= addr_i;
      len_o   <= len_i;
      wdata_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      rsp_exc_o   <= 1'b0;
      rsp_tmo_o   <= 1'b0;
    end else begin
      rsp_valid_o <= done_i;
      if (done_i) begin
        rsp_rdata_o <= ld_cap_i ? ld_data_i : '0;
        rsp_exc_o   <= (kind_i == END_EXC);
        rsp_tmo_o   <= (kind_i == END_TMO);
      end
    end
  end
endmodule

// File: rtl/ldst_req_master.sv
module ldst_req_master
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 64,
  parameter int LEN_W  = 4,
  parameter int TMO_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_is_st_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  input  logic              abort_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_exc_o,
  output logic              rsp_tmo_o,
  output logic              pt_ld_o,
  output logic              pt_st_o,
  output logic [ADDR_W-1:0] pt_addr_o,
  output logic              pt_addr_vld_o,
  output logic [LEN_W-1:0]  pt_len_o,
  output logic              pt_abort_o,
  input  logic              pt_busy_i,
  input  logic              pt_addr_ack_i,
  input  logic              pt_exc_i,
  input  logic              pt_ld_vld_i,
  input  logic [DATA_W-1:0] pt_ld_data_i,
  output logic              pt_st_vld_o,
  output logic [DATA_W-1:0] pt_st_data_o
);
  ldst_st_e  state;
  ldst_end_e kind;
  logic      fire, clr, done, ld_cap, expire, run, active, is_st_q;

  assign cmd_ready_o = (state == ST_IDLE) && !pt_busy_i;
  assign fire        = cmd_valid_i && cmd_ready_o;
  assign active      = (state != ST_IDLE);
  assign run         = (state == ST_ADDR) || (state == ST_LDAT) || (state == ST_SDRN);

  ldst_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .is_st_i  (is_st_q),
    .abort_i  (abort_i),
    .busy_i   (pt_busy_i),
    .ack_i    (pt_addr_ack_i),
    .exc_i    (pt_exc_i),
    .ld_vld_i (pt_ld_vld_i),
    .expire_i (expire),
    .state_o  (state),
    .clr_o    (clr),
    .done_o   (done),
    .kind_o   (kind),
    .ld_cap_o (ld_cap),
    .abort_o  (pt_abort_o)
  );

  ldst_tmo #(.TMO_W(TMO_W)) u_tmo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .run_i    (run),
    .limit_i  (tmo_limit_i),
    .expire_o (expire)
  );

  ldst_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_dpath (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (fire),
    .is_st_i     (cmd_is_st_i),
    .addr_i      (cmd_addr_i),
    .len_i       (cmd_len_i),
    .wdata_i     (cmd_wdata_i),
    .done_i      (done),
    .kind_i      (kind),
    .ld_cap_i    (ld_cap),
    .ld_data_i   (pt_ld_data_i),
    .is_st_o     (is_st_q),
    .addr_o      (pt_addr_o),
    .len_o       (pt_len_o),
    .wdata_o     (pt_st_data_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .rsp_exc_o   (rsp_exc_o),
    .rsp_tmo_o   (rsp_tmo_o)
  );

  assign pt_ld_o       = active && !is_st_q;
  assign pt_st_o       = active && is_st_q;
  assign pt_addr_vld_o = active;
  assign pt_st_vld_o   = (state == ST_SPUL);
endmodule

// File: rtl/ldst_req_master_chk.sv
module ldst_req_master_chk #(
  parameter int ADDR_W = 48
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_ready_o,
  input logic              abort_i,
  input logic              rsp_valid_o,
  input logic              rsp_exc_o,
  input logic              pt_ld_o,
  input logic              pt_st_o,
  input logic [ADDR_W-1:0] pt_addr_o,
  input logic              pt_addr_vld_o,
  input logic              pt_abort_o,
  input logic              pt_busy_i,
  input logic              pt_addr_ack_i,
  input logic              pt_exc_i,
  input logic              pt_st_vld_o
);
  a_r1_one_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pt_ld_o, pt_st_o}));
  a_r1_req_with_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pt_ld_o || pt_st_o) == pt_addr_vld_o);
  a_r2_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pt_addr_vld_o |=> (!pt_addr_vld_o || $stable(pt_addr_o)));
  a_r4_exc_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pt_addr_vld_o && pt_exc_i && !abort_i) |=> (rsp_valid_o && rsp_exc_o));
  a_r6_st_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pt_st_vld_o) |-> $past(pt_addr_ack_i));
  a_r6_st_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pt_st_vld_o |=> !pt_st_vld_o);
  a_r7_no_done_on_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pt_st_vld_o && !pt_exc_i) |=> !rsp_valid_o);
  a_r9_abort_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pt_abort_o |=> !pt_abort_o);
  a_r9_abort_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pt_abort_o |-> (!pt_addr_vld_o && !rsp_valid_o));
  a_r10_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (!pt_busy_i && !pt_addr_vld_o));
  a_r11_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

bind ldst_req_master ldst_req_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_ready_o   (cmd_ready_o),
  .abort_i       (abort_i),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_exc_o     (rsp_exc_o),
  .pt_ld_o       (pt_ld_o),
  .pt_st_o       (pt_st_o),
  .pt_addr_o     (pt_addr_o),
  .pt_addr_vld_o (pt_addr_vld_o),
  .pt_abort_o    (pt_abort_o),
  .pt_busy_i     (pt_busy_i),
  .pt_addr_ack_i (pt_addr_ack_i),
  .pt_exc_i      (pt_exc_i),
  .pt_st_vld_o   (pt_st_vld_o)
);

// File: tb/sim_ldst_req_master.sv
module sim_ldst_req_master;
  localparam int TMO = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0, cmd_ready_o, cmd_is_st_i = 1'b0;
  logic [47:0] cmd_addr_i = '0;
  logic [3:0]  cmd_len_i = '0;
  logic [63:0] cmd_wdata_i = '0;
  logic        abort_i = 1'b0;
  logic [15:0] tmo_limit_i = 16'(TMO);
  logic        rsp_valid_o, rsp_exc_o, rsp_tmo_o;
  logic [63:0] rsp_rdata_o;
  logic        pt_ld_o, pt_st_o, pt_addr_vld_o, pt_abort_o, pt_st_vld_o;
  logic [47:0] pt_addr_o;
  logic [3:0]  pt_len_o;
  logic        pt_busy_i = 1'b0, pt_addr_ack_i = 1'b0, pt_exc_i = 1'b0, pt_ld_vld_i = 1'b0;
  logic [63:0] pt_ld_data_i = '0, pt_st_data_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk_i = ~clk_i;

  ldst_req_master u0 (.*);

  // mode: 0 ack, 1 exception, 2 no address answer, 3 ack but no load data
  typedef struct packed {
    logic        is_st;
    logic [47:0] addr;
    logic [3:0]  len;
    logic [63:0] wdata;
    logic [1:0]  mode;
    logic [3:0]  d1;
    logic [3:0]  d2;
    logic [63:0] ldata;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 48'h0000_1234_5678, 4'd8, 64'h0,                   2'd0, 4'd0, 4'd0, 64'h1122_3344_5566_7788},
    '{1'b0, 48'hABCD_0000_0010, 4'd1, 64'h0,                   2'd0, 4'd2, 4'd3, 64'h0000_0000_0000_00A5},
    '{1'b1, 48'h0000_0000_0F00, 4'd8, 64'hDEAD_BEEF_CAFE_F00D, 2'd0, 4'd0, 4'd0, 64'h0},
    '{1'b1, 48'h7FFF_FFFF_FFF8, 4'd4, 64'h0000_0000_1357_9BDF, 2'd0, 4'd3, 4'd2, 64'h0},
    '{1'b0, 48'h0000_0000_0040, 4'd2, 64'h0,                   2'd1, 4'd1, 4'd0, 64'h0},
    '{1'b1, 48'h0000_0000_0048, 4'd8, 64'hFFFF_0000_FFFF_0000, 2'd1, 4'd0, 4'd0, 64'h0},
    '{1'b0, 48'h1000_0000_0000, 4'd8, 64'h0,                   2'd2, 4'd0, 4'd0, 64'h0},
    '{1'b1, 48'h2000_0000_0000, 4'd8, 64'h0123_4567_89AB_CDEF, 2'd2, 4'd0, 4'd0, 64'h0},
    '{1'b0, 48'h3000_0000_0008, 4'd8, 64'h0,                   2'd3, 4'd1, 4'd0, 64'h0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_rsp(output int n);
    n = 0;
    while (!rsp_valid_o && n < 40) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  task automatic issue(input logic st, input logic [47:0] a, input logic [3:0] l, input logic [63:0] w);
    cmd_valid_i = 1'b1; cmd_is_st_i = st; cmd_addr_i = a; cmd_len_i = l; cmd_wdata_i = w;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    pt_busy_i = 1'b1;
  endtask

  task automatic after_rsp(input bit still_busy);
    @(negedge clk_i);
    chk(rsp_valid_o == 1'b0, "R11 rsp one cycle", 64'(rsp_valid_o), 64'd0);
    chk(pt_addr_vld_o == 1'b0, "R2 addr released", 64'(pt_addr_vld_o), 64'd0);
    if (still_busy) begin
      chk(cmd_ready_o == 1'b0, "R10 not ready while busy", 64'(cmd_ready_o), 64'd0);
      pt_busy_i = 1'b0;
      @(negedge clk_i);
    end
    chk(cmd_ready_o == 1'b1, "R10 ready when idle", 64'(cmd_ready_o), 64'd1);
  endtask

  task automatic run_vec(input vec_t v);
    int n;
    logic [63:0] exp_rd;
    issue(v.is_st, v.addr, v.len, v.wdata);
    chk(pt_ld_o == !v.is_st && pt_st_o == v.is_st, "R1 request line",
        64'({pt_ld_o, pt_st_o}), 64'({!v.is_st, v.is_st}));
    chk(pt_addr_vld_o && pt_addr_o == v.addr && pt_len_o == v.len, "R2 addr/len",
        64'(pt_addr_o), 64'(v.addr));
    chk(cmd_ready_o == 1'b0, "R10 busy transaction", 64'(cmd_ready_o), 64'd0);
    if (v.mode == 2'd2) begin
      wait_rsp(n);
      chk(n == TMO, "R8 address timeout cycle", 64'(n), 64'(TMO));
      chk(rsp_valid_o && rsp_tmo_o && !rsp_exc_o && rsp_rdata_o == '0, "R8 timeout response",
          {rsp_tmo_o, rsp_exc_o, 62'(rsp_rdata_o)}, {1'b1, 63'd0});
      after_rsp(1'b1);
      return;
    end
    for (int i = 0; i < int'(v.d1); i++) begin
      @(negedge clk_i);
      chk(pt_addr_o == v.addr && pt_addr_vld_o, "R2 addr held", 64'(pt_addr_o), 64'(v.addr));
      chk(pt_st_vld_o == 1'b0, "R6 no data before ack", 64'(pt_st_vld_o), 64'd0);
    end
    if (v.mode == 2'd1) begin
      pt_exc_i = 1'b1;
      @(negedge clk_i);
      pt_exc_i = 1'b0; pt_busy_i = 1'b0;
      chk(rsp_valid_o && rsp_exc_o && !rsp_tmo_o && rsp_rdata_o == '0, "R4 exception response",
          {rsp_valid_o, rsp_exc_o, rsp_tmo_o, 61'(rsp_rdata_o)}, {3'b110, 61'd0});
      after_rsp(1'b0);
      return;
    end
    pt_addr_ack_i = 1'b1;
    @(negedge clk_i);
    pt_addr_ack_i = 1'b0;
    if (v.is_st) begin
      chk(pt_st_vld_o && pt_st_data_o == v.wdata, "R6 store pulse", pt_st_data_o, v.wdata);
      chk(pt_addr_o == v.addr && pt_st_o, "R2 addr held at pulse", 64'(pt_addr_o), 64'(v.addr));
      @(negedge clk_i);
      for (int i = 0; i < int'(v.d2); i++) begin
        chk(pt_st_vld_o == 1'b0 && !rsp_valid_o, "R7 wait busy", 64'({pt_st_vld_o, rsp_valid_o}), 64'd0);
        @(negedge clk_i);
      end
      chk(pt_st_vld_o == 1'b0, "R6 pulse single", 64'(pt_st_vld_o), 64'd0);
      pt_busy_i = 1'b0;
      @(negedge clk_i);
      chk(rsp_valid_o && !rsp_exc_o && !rsp_tmo_o && rsp_rdata_o == '0, "R7 store complete",
          {rsp_valid_o, rsp_exc_o, rsp_tmo_o, 61'(rsp_rdata_o)}, {3'b100, 61'd0});
      after_rsp(1'b0);
    end else if (v.mode == 2'd3) begin
      wait_rsp(n);
      chk(n == TMO, "R8 load data timeout cycle", 64'(n), 64'(TMO));
      chk(rsp_valid_o && rsp_tmo_o, "R8 load data timeout", 64'(rsp_tmo_o), 64'd1);
      after_rsp(1'b1);
    end else begin
      for (int i = 0; i < int'(v.d2); i++) begin
        chk(!rsp_valid_o && pt_ld_o, "R3 load waits data", 64'(rsp_valid_o), 64'd0);
        @(negedge clk_i);
      end
      pt_ld_vld_i = 1'b1; pt_ld_data_i = v.ldata; pt_busy_i = 1'b0;
      @(negedge clk_i);
      pt_ld_vld_i = 1'b0; pt_ld_data_i = '0;
      exp_rd = v.ldata;
      chk(rsp_valid_o && !rsp_exc_o && !rsp_tmo_o && rsp_rdata_o == exp_rd, "R5 load data",
          rsp_rdata_o, exp_rd);
      after_rsp(1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    chk(!pt_ld_o && !pt_st_o && !pt_addr_vld_o && !pt_st_vld_o && !pt_abort_o && !rsp_valid_o,
        "R1 reset quiet", 64'({pt_ld_o, pt_st_o, pt_addr_vld_o, pt_st_vld_o, pt_abort_o, rsp_valid_o}), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cmd_ready_o == 1'b1, "R10 ready after reset", 64'(cmd_ready_o), 64'd1);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R9: abort during the address phase
    issue(1'b0, 48'h55, 4'd8, 64'h0);
    abort_i = 1'b1;
    @(negedge clk_i);
    abort_i = 1'b0;
    chk(pt_abort_o && !pt_ld_o && !pt_addr_vld_o && !rsp_valid_o, "R9 abort pulse",
        64'({pt_abort_o, pt_ld_o, pt_addr_vld_o, rsp_valid_o}), 64'b1000);
    pt_busy_i = 1'b0;
    @(negedge clk_i);
    chk(!pt_abort_o && !rsp_valid_o && cmd_ready_o, "R9 abort single, no response",
        64'({pt_abort_o, rsp_valid_o, cmd_ready_o}), 64'b001);

    // R9: abort while idle has no effect
    abort_i = 1'b1;
    @(negedge clk_i);
    abort_i = 1'b0;
    chk(!pt_abort_o && cmd_ready_o, "R9 idle abort ignored", 64'({pt_abort_o, cmd_ready_o}), 64'b01);

    // R4: exception beats a simultaneous acknowledge on a store
    issue(1'b1, 48'h66, 4'd8, 64'hAAAA);
    pt_addr_ack_i = 1'b1; pt_exc_i = 1'b1;
    @(negedge clk_i);
    pt_addr_ack_i = 1'b0; pt_exc_i = 1'b0; pt_busy_i = 1'b0;
    chk(rsp_valid_o && rsp_exc_o && !pt_st_vld_o, "R4 exc over ack",
        64'({rsp_valid_o, rsp_exc_o, pt_st_vld_o}), 64'b110);
    after_rsp(1'b0);

    // R5: load data during the address phase is ignored
    issue(1'b0, 48'h77, 4'd4, 64'h0);
    pt_ld_vld_i = 1'b1; pt_ld_data_i = 64'hBAD;
    @(negedge clk_i);
    pt_ld_vld_i = 1'b0;
    chk(!rsp_valid_o && pt_ld_o, "R5 early data ignored", 64'(rsp_valid_o), 64'd0);
    pt_addr_ack_i = 1'b1;
    @(negedge clk_i);
    pt_addr_ack_i = 1'b0;
    pt_ld_vld_i = 1'b1; pt_ld_data_i = 64'h600D; pt_busy_i = 1'b0;
    @(negedge clk_i);
    pt_ld_vld_i = 1'b0;
    chk(rsp_valid_o && rsp_rdata_o == 64'h600D, "R5 later data taken", rsp_rdata_o, 64'h600D);
    after_rsp(1'b0);

    // R8: limit zero disables timeout
    tmo_limit_i = '0;
    issue(1'b0, 48'h88, 4'd8, 64'h0);
    repeat (20) @(negedge clk_i);
    chk(!rsp_valid_o && pt_addr_vld_o, "R8 no timeout at zero", 64'(rsp_valid_o), 64'd0);
    pt_addr_ack_i = 1'b1;
    @(negedge clk_i);
    pt_addr_ack_i = 1'b0;
    pt_ld_vld_i = 1'b1; pt_ld_data_i = 64'h42; pt_busy_i = 1'b0;
    @(negedge clk_i);
    pt_ld_vld_i = 1'b0;
    chk(rsp_valid_o && !rsp_tmo_o && rsp_rdata_o == 64'h42, "R8 zero limit completes",
        rsp_rdata_o, 64'h42);
    tmo_limit_i = 16'(TMO);

    // R10: command offered while port busy is not taken
    @(negedge clk_i);
    pt_busy_i = 1'b1;
    cmd_valid_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!pt_addr_vld_o && !cmd_ready_o, "R10 held off by busy", 64'(pt_addr_vld_o), 64'd0);
    cmd_valid_i = 1'b0;
    pt_busy_i = 1'b0;
    wait_rsp(n);
    chk(n == 40, "R11 no stray response", 64'(n), 64'd40);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule